// File: doc/BRIEF.md
# Shared-Bus Load/Store Lane Steering Port

This block connects a 32-bit RISC pipeline to a single word-wide memory bus that carries both instruction fetches and data accesses. On ordinary cycles it presents the fetch address supplied by the program-counter logic. When the execute stage raises a load or store request, it takes the bus for one extra cycle. During that cycle it shows the data word address, the byte write enables for the lanes being written and the store data copied into every lane. Fetch resumes on the cycle after.

For loads, it picks the addressed byte or halfword out of the returned word and widens it to 32 bits, with sign or zero extension. A parameter selects the byte order. The same next-cycle address and write-enable values that feed the bus registers are also driven out one clock early, so that a synchronous RAM can be addressed. An active-high pause input freezes every bus register and holds the pipeline stall for as long as it stays high. Word and halfword accesses are assumed to be naturally aligned.

Top module: `mem_lane_port`

## Requirements
- R1: While `rst_n` is low, `addr_o` equals bits 31:2 of `RESET_VEC`, `be_o` is 0000 and `wdata_o` is zero.
- R2: In a fetch cycle with no request and no pause, the next cycle shows `addr_o` equal to the `fetch_addr_i` value from the previous cycle, with `be_o` = 0000 (fetches never write).
- R3: A request (`req_valid_i`) seen in a fetch cycle raises `stall_o` in that cycle. The next cycle is a data cycle in which `addr_o` = `req_addr_i[31:2]`. The cycle after that returns to fetch, using the `fetch_addr_i` value presented during the data cycle. A request seen during a data cycle is ignored.
- R4: A byte store (`req_size_i` = 0) drives the low byte of `req_wdata_i` into all four lanes of `wdata_o` and sets exactly one `be_o` bit. In big-endian order, byte offset 0 maps to `be_o[3]` and offset 3 maps to `be_o[0]`.
- R5: A halfword store (`req_size_i` = 1) drives the low 16 bits of `req_wdata_i` into both halves and sets two `be_o` bits. In big-endian order, address bit 1 = 0 selects 1100 and address bit 1 = 1 selects 0011. `be_o` never has exactly three bits set.
- R6: A word store (`req_size_i` = 2) passes `req_wdata_i` through unchanged with `be_o` = 1111. A word load returns `rdata_i` unchanged.
- R7: Loads keep `be_o` at 0000. During the data cycle, a byte load returns the addressed lane of `rdata_i`, sign-extended when `req_signed_i` = 1 and zero-extended otherwise.
- R8: A halfword load returns the half chosen by address bit 1 (big-endian: bit 1 = 0 selects `rdata_i[31:16]`), sign- or zero-extended.
- R9: With `BIG_ENDIAN` = 0 the lane mapping is mirrored. Byte offset k maps to `be_o[k]` and lane k, and address bit 1 = 1 selects the upper half.
- R10: While `pause_i` is high, `addr_o`, `be_o`, `wdata_o` and the fetch/data phase hold their values, `addr_next_o` equals `addr_o`, and `stall_o` is high.
- R11: `addr_next_o` and `be_next_o` always equal the values that `addr_o` and `be_o` take at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| pause_i | input | 1 | Freeze bus state and stall the pipeline |
| fetch_addr_i | input | ADDR_W-2 | Word address of the next instruction fetch |
| req_valid_i | input | 1 | Load/store request from execute |
| req_write_i | input | 1 | 1 = store, 0 = load |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2 word |
| req_signed_i | input | 1 | Sign-extend narrow loads |
| req_addr_i | input | ADDR_W | Byte address of the data access |
| req_wdata_i | input | 32 | Store datum, right-aligned |
| rdata_i | input | 32 | Read data from memory in the current cycle |
| addr_next_o | output | ADDR_W-2 | Word address for the next cycle |
| be_next_o | output | 4 | Byte write enables for the next cycle |
| addr_o | output | ADDR_W-2 | Current word address |
| be_o | output | 4 | Current byte write enables |
| wdata_o | output | 32 | Lane-replicated store data |
| load_data_o | output | 32 | Aligned, extended load result |
| stall_o | output | 1 | Pipeline hold |

## Verification
`stall_o`, `addr_next_o` and `be_next_o` are combinational, so each check samples them one nanosecond after the inputs change at the falling edge, within the same cycle. `addr_o`, `be_o` and `wdata_o` pass through one register, so they are checked two nanoseconds after the next rising edge. `load_data_o` is checked in that same data cycle, because it follows `rdata_i` with no further register. The return to fetch is checked one rising edge later again. Under pause, the checks move out by exactly the number of paused edges.

// File: rtl/mem_lane_pkg.sv
package mem_lane_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned LANES  = DATA_W / 8;
  localparam int unsigned OFF_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } size_e;

  typedef enum logic {
    PH_FETCH = 1'b0,
    PH_DATA  = 1'b1
  } phase_e;
endpackage

// File: rtl/mem_store_steer.sv
module mem_store_steer
  import mem_lane_pkg::*;
#(
  parameter bit BIG_ENDIAN = 1'b1
) (
  input  logic              wr_i,
  input  size_e             size_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [LANES-1:0]  be_o,
  output logic [DATA_W-1:0] wdata_o
);
  logic [OFF_W-1:0] lane;
  logic             half_hi;

  // byte order picks how an address offset lands on a lane
  generate
    if (BIG_ENDIAN) begin : g_big
      assign lane    = OFF_W'(LANES - 1) - off_i;
      assign half_hi = ~off_i[1];
    end else begin : g_little
      assign lane    = off_i;
      assign half_hi = off_i[1];
    end
  endgenerate

  always_comb begin
    be_o    = '0;
    wdata_o = wdata_i;
    case (size_i)
      SZ_BYTE: begin
        wdata_o    = {LANES{wdata_i[7:0]}};
        be_o[lane] = wr_i;
      end
      SZ_HALF: begin
        wdata_o = {2{wdata_i[15:0]}};
        if (wr_i) be_o = half_hi ? 4'b1100 : 4'b0011;
      end
      default: begin
        be_o = {LANES{wr_i}};
      end
    endcase
  end
endmodule

// File: rtl/mem_load_align.sv
module mem_load_align
  import mem_lane_pkg::*;
#(
  parameter bit BIG_ENDIAN = 1'b1
) (
  input  size_e             size_i,
  input  logic              sign_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] data_o
);
  logic [OFF_W-1:0] lane;
  logic             half_hi;
  logic [7:0]       byte_v;
  logic [15:0]      half_v;

  generate
    if (BIG_ENDIAN) begin : g_big
      assign lane    = OFF_W'(LANES - 1) - off_i;
      assign half_hi = ~off_i[1];
    end else begin : g_little
      assign lane    = off_i;
      assign half_hi = off_i[1];
    end
  endgenerate

  always_comb begin
    byte_v = rdata_i[{lane, 3'b000} +: 8];
    half_v = half_hi ? rdata_i[31:16] : rdata_i[15:0];
    case (size_i)
      SZ_BYTE: data_o = {{24{sign_i & byte_v[7]}}, byte_v};
      SZ_HALF: data_o = {{16{sign_i & half_v[15]}}, half_v};
      default: data_o = rdata_i;
    endcase
  end
endmodule

// File: rtl/mem_bus_seq.sv
module mem_bus_seq
  import mem_lane_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pause_i,
  input  logic [ADDR_W-1:2] fetch_addr_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  size_e             req_size_i,
  input  logic              req_sign_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LANES-1:0]  st_be_i,
  input  logic [DATA_W-1:0] st_data_i,
  output logic [ADDR_W-1:2] addr_next_o,
  output logic [LANES-1:0]  be_next_o,
  output logic [ADDR_W-1:2] addr_o,
  output logic [LANES-1:0]  be_o,
  output logic [DATA_W-1:0] wdata_o,
  output phase_e            phase_o,
  output size_e             ld_size_o,
  output logic              ld_sign_o,
  output logic [OFF_W-1:0]  ld_off_o,
  output logic              stall_o
);
  phase_e            phase_q, phase_d;
  logic [ADDR_W-1:2] addr_q, addr_d;
  logic [LANES-1:0]  be_q, be_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  size_e             ld_size_q;
  logic              ld_sign_q;
  logic [OFF_W-1:0]  ld_off_q;
  logic              take;
  logic              ld_en;

  assign take  = (phase_q == PH_FETCH) && req_valid_i;
  assign ld_en = take && !pause_i;

  always_comb begin
    phase_d = phase_q;
    addr_d  = addr_q;
    be_d    = be_q;
    wdata_d = wdata_q;
    if (!pause_i) begin
      if (take) begin
        phase_d = PH_DATA;
        addr_d  = req_addr_i[ADDR_W-1:2];
        be_d    = st_be_i;
        wdata_d = req_write_i ? st_data_i : '0;
      end else begin
        phase_d = PH_FETCH;
        addr_d  = fetch_addr_i;
        be_d    = '0;
        wdata_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_FETCH;
      addr_q  <= RESET_VEC[ADDR_W-1:2];
      be_q    <= '0;
      wdata_q <= '0;
    end else begin
      phase_q <= phase_d;
      addr_q  <= addr_d;
      be_q    <= be_d;
      wdata_q <= wdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_size_q <= SZ_WORD;
      ld_sign_q <= 1'b0;
      ld_off_q  <= '0;
    end else if (ld_en) begin
      ld_size_q <= req_size_i;
      ld_sign_q <= req_sign_i;
      ld_off_q  <= req_addr_i[OFF_W-1:0];
    end
  end

  assign addr_next_o = addr_d;
  assign be_next_o   = be_d;
  assign addr_o      = addr_q;
  assign be_o        = be_q;
  assign wdata_o     = wdata_q;
  assign phase_o     = phase_q;
  assign ld_size_o   = ld_size_q;
  assign ld_sign_o   = ld_sign_q;
  assign ld_off_o    = ld_off_q;
  assign stall_o     = pause_i || take;
endmodule

// File: rtl/mem_lane_port.sv
module mem_lane_port
  import mem_lane_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] RESET_VEC  = '0,
  parameter bit                BIG_ENDIAN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pause_i,
  input  logic [ADDR_W-1:2] fetch_addr_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [1:0]        req_size_i,
  input  logic              req_signed_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [31:0]       req_wdata_i,
  input  logic [31:0]       rdata_i,
  output logic [ADDR_W-1:2] addr_next_o,
  output logic [3:0]        be_next_o,
  output logic [ADDR_W-1:2] addr_o,
  output logic [3:0]        be_o,
  output logic [31:0]       wdata_o,
  output logic [31:0]       load_data_o,
  output logic              stall_o
);
  size_e             req_size;
  logic [LANES-1:0]  st_be;
  logic [DATA_W-1:0] st_data;
  phase_e            phase;
  size_e             ld_size;
  logic              ld_sign;
  logic [OFF_W-1:0]  ld_off;

  assign req_size = size_e'(req_size_i);

  mem_store_steer #(.BIG_ENDIAN(BIG_ENDIAN)) u_steer (
    .wr_i    (req_write_i),
    .size_i  (req_size),
    .off_i   (req_addr_i[OFF_W-1:0]),
    .wdata_i (req_wdata_i),
    .be_o    (st_be),
    .wdata_o (st_data)
  );

  mem_bus_seq #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .pause_i      (pause_i),
    .fetch_addr_i (fetch_addr_i),
    .req_valid_i  (req_valid_i),
    .req_write_i  (req_write_i),
    .req_size_i   (req_size),
    .req_sign_i   (req_signed_i),
    .req_addr_i   (req_addr_i),
    .st_be_i      (st_be),
    .st_data_i    (st_data),
    .addr_next_o  (addr_next_o),
    .be_next_o    (be_next_o),
    .addr_o       (addr_o),
    .be_o         (be_o),
    .wdata_o      (wdata_o),
    .phase_o      (phase),
    .ld_size_o    (ld_size),
    .ld_sign_o    (ld_sign),
    .ld_off_o     (ld_off),
    .stall_o      (stall_o)
  );

  mem_load_align #(.BIG_ENDIAN(BIG_ENDIAN)) u_align (
    .size_i  (ld_size),
    .sign_i  (ld_sign),
    .off_i   (ld_off),
    .rdata_i (rdata_i),
    .data_o  (load_data_o)
  );
endmodule

// File: rtl/mem_lane_port_chk.sv
module mem_lane_port_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pause_i,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [ADDR_W-1:2] addr_next_o,
  input logic [3:0]        be_next_o,
  input logic [ADDR_W-1:2] addr_o,
  input logic [3:0]        be_o,
  input logic              phase_i
);
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  // R11: early outputs preview the registered bus one edge ahead
  p_early_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> (addr_o == $past(addr_next_o)) && (be_o == $past(be_next_o)));

  // R2: a fetch cycle never carries write enables
  p_fetch_no_we_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_i |-> (be_o == 4'b0000));

  // R3: an accepted request becomes the data cycle at its address
  p_steal_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase_i && req_valid_i && !pause_i) |=>
      (phase_i && addr_o == $past(req_addr_i[ADDR_W-1:2])));

  // R3: a data cycle lasts one cycle unless paused
  p_data_returns_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i && !pause_i) |=> !phase_i);

  // R10: pause freezes the bus registers
  p_pause_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pause_i |=> ($stable(addr_o) && $stable(be_o) && $stable(phase_i)));

  // R5: lane groups are one, two or four lanes, never three
  p_lane_group_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(be_o) != 3);
endmodule

bind mem_lane_port mem_lane_port_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pause_i     (pause_i),
  .req_valid_i (req_valid_i),
  .req_addr_i  (req_addr_i),
  .addr_next_o (addr_next_o),
  .be_next_o   (be_next_o),
  .addr_o      (addr_o),
  .be_o        (be_o),
  .phase_i     (phase)
);

// File: tb/mem_lane_port_bench.sv
module mem_lane_port_bench;
  localparam logic [31:0] RVEC = 32'hBFC0_0000;
  localparam logic [31:0] RD   = 32'h817F_C324;

  typedef struct packed {
    logic        wr;
    logic [1:0]  sz;
    logic        sg;
    logic [1:0]  off;
    logic [31:0] dat;
    logic [3:0]  be_b;
    logic [3:0]  be_l;
    logic [31:0] exp_b;
    logic [31:0] exp_l;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd0, 1'b0, 2'd3, 32'h0000_0041, 4'b0001, 4'b1000, 32'h4141_4141, 32'h4141_4141},
    '{1'b1, 2'd0, 1'b0, 2'd0, 32'h0000_00A5, 4'b1000, 4'b0001, 32'hA5A5_A5A5, 32'hA5A5_A5A5},
    '{1'b1, 2'd0, 1'b0, 2'd1, 32'h1234_5666, 4'b0100, 4'b0010, 32'h6666_6666, 32'h6666_6666},
    '{1'b1, 2'd1, 1'b0, 2'd0, 32'h0000_BEEF, 4'b1100, 4'b0011, 32'hBEEF_BEEF, 32'hBEEF_BEEF},
    '{1'b1, 2'd1, 1'b0, 2'd2, 32'hFFFF_1234, 4'b0011, 4'b1100, 32'h1234_1234, 32'h1234_1234},
    '{1'b1, 2'd2, 1'b0, 2'd0, 32'hCAFE_F00D, 4'b1111, 4'b1111, 32'hCAFE_F00D, 32'hCAFE_F00D},
    '{1'b0, 2'd0, 1'b1, 2'd0, RD,            4'b0000, 4'b0000, 32'hFFFF_FF81, 32'h0000_0024},
    '{1'b0, 2'd0, 1'b0, 2'd0, RD,            4'b0000, 4'b0000, 32'h0000_0081, 32'h0000_0024},
    '{1'b0, 2'd0, 1'b1, 2'd2, RD,            4'b0000, 4'b0000, 32'hFFFF_FFC3, 32'h0000_007F},
    '{1'b0, 2'd0, 1'b0, 2'd3, RD,            4'b0000, 4'b0000, 32'h0000_0024, 32'h0000_0081},
    '{1'b0, 2'd1, 1'b1, 2'd0, RD,            4'b0000, 4'b0000, 32'hFFFF_817F, 32'hFFFF_C324},
    '{1'b0, 2'd1, 1'b0, 2'd2, RD,            4'b0000, 4'b0000, 32'h0000_C324, 32'h0000_817F},
    '{1'b0, 2'd2, 1'b0, 2'd0, RD,            4'b0000, 4'b0000, 32'h817F_C324, 32'h817F_C324}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pause_i;
  logic [31:2] fetch_addr_i;
  logic        req_valid_i, req_write_i, req_signed_i;
  logic [1:0]  req_size_i;
  logic [31:0] req_addr_i, req_wdata_i, rdata_i;

  logic [31:2] an_b, an_l, a_b, a_l;
  logic [3:0]  bn_b, bn_l, b_b, b_l;
  logic [31:0] w_b, w_l, ld_b, ld_l;
  logic        st_b, st_l;

  int n_tests = 0;
  int n_fail  = 0;
  bit reported = 1'b0;

  always #4 clk = ~clk;

  mem_lane_port #(.ADDR_W(32), .RESET_VEC(RVEC), .BIG_ENDIAN(1'b1)) u_mem_lane_port (
    .clk(clk), .rst_n(rst_n), .pause_i(pause_i), .fetch_addr_i(fetch_addr_i),
    .req_valid_i(req_valid_i), .req_write_i(req_write_i), .req_size_i(req_size_i),
    .req_signed_i(req_signed_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .rdata_i(rdata_i), .addr_next_o(an_b), .be_next_o(bn_b), .addr_o(a_b), .be_o(b_b),
    .wdata_o(w_b), .load_data_o(ld_b), .stall_o(st_b));

  mem_lane_port #(.ADDR_W(32), .RESET_VEC(RVEC), .BIG_ENDIAN(1'b0)) u_mem_lane_port_le (
    .clk(clk), .rst_n(rst_n), .pause_i(pause_i), .fetch_addr_i(fetch_addr_i),
    .req_valid_i(req_valid_i), .req_write_i(req_write_i), .req_size_i(req_size_i),
    .req_signed_i(req_signed_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .rdata_i(rdata_i), .addr_next_o(an_l), .be_next_o(bn_l), .addr_o(a_l), .be_o(b_l),
    .wdata_o(w_l), .load_data_o(ld_l), .stall_o(st_l));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  function automatic string tag_of(input vec_t v);
    if (v.wr) begin
      if (v.sz == 2'd0)      return "R4 byte store";
      else if (v.sz == 2'd1) return "R5 half store";
      else                   return "R6 word store";
    end else begin
      if (v.sz == 2'd0)      return "R7 byte load";
      else if (v.sz == 2'd1) return "R8 half load";
      else                   return "R6 word load";
    end
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin : stim
    logic [31:0] a;
    logic [31:0] f;
    rst_n        = 1'b0;
    pause_i      = 1'b0;
    fetch_addr_i = '0;
    req_valid_i  = 1'b0;
    req_write_i  = 1'b0;
    req_signed_i = 1'b0;
    req_size_i   = 2'd0;
    req_addr_i   = '0;
    req_wdata_i  = '0;
    rdata_i      = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 addr", {2'b00, a_b}, {2'b00, RVEC[31:2]});
    chk("R1 be", {28'd0, b_b}, 32'd0);
    chk("R1 wdata", w_b, 32'd0);
    rst_n = 1'b1;

    // R2: plain fetch follows fetch_addr_i one cycle later, no writes
    fetch_addr_i = 30'h0000_1111;
    #1;
    chk("R11 fetch early addr", {2'b00, an_b}, 32'h0000_1111);
    chk("R2 no stall", {31'd0, st_b}, 32'd0);
    @(posedge clk); #2;
    chk("R2 fetch addr", {2'b00, a_b}, 32'h0000_1111);
    chk("R2 fetch be", {28'd0, b_b}, 32'd0);

    // table walk: request, data cycle, return to fetch
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      a = 32'h0000_FF00 + 32'(i * 4) + {30'd0, VECS[i].off};
      if (i == 0) a = 32'h0000_FFFF;
      f = 32'h0000_2000 + 32'(i);
      req_valid_i  = 1'b1;
      req_write_i  = VECS[i].wr;
      req_size_i   = VECS[i].sz;
      req_signed_i = VECS[i].sg;
      req_addr_i   = a;
      req_wdata_i  = VECS[i].dat;
      rdata_i      = VECS[i].dat;
      #1;
      chk("R3 stall on request", {31'd0, st_b}, 32'd1);
      chk("R11 early data addr", {2'b00, an_b}, {2'b00, a[31:2]});
      chk("R11 early be", {28'd0, bn_b}, {28'd0, VECS[i].be_b});
      @(posedge clk); #2;
      chk("R3 data addr", {2'b00, a_b}, {2'b00, a[31:2]});
      chk(tag_of(VECS[i]), {28'd0, b_b}, {28'd0, VECS[i].be_b});
      chk("R9 mirrored be", {28'd0, b_l}, {28'd0, VECS[i].be_l});
      if (VECS[i].wr) begin
        chk(tag_of(VECS[i]), w_b, VECS[i].exp_b);
        chk("R9 mirrored wdata", w_l, VECS[i].exp_l);
      end else begin
        chk(tag_of(VECS[i]), ld_b, VECS[i].exp_b);
        chk("R9 mirrored load", ld_l, VECS[i].exp_l);
      end
      req_valid_i  = 1'b0;
      fetch_addr_i = f[29:0];
      @(posedge clk); #2;
      chk("R3 fetch resumes", {2'b00, a_b}, f);
      chk("R3 fetch be", {28'd0, b_b}, 32'd0);
    end

    // R3: a request held during the data cycle is ignored
    @(negedge clk);
    req_valid_i = 1'b1; req_write_i = 1'b1; req_size_i = 2'd2;
    req_addr_i = 32'h0000_4000; req_wdata_i = 32'h1111_2222;
    @(posedge clk); #2;
    req_addr_i   = 32'h0000_5000;
    fetch_addr_i = 30'h0000_3000;
    @(posedge clk); #2;
    chk("R3 request in data cycle ignored addr", {2'b00, a_b}, 32'h0000_3000);
    chk("R3 request in data cycle ignored be", {28'd0, b_b}, 32'd0);
    req_valid_i = 1'b0;

    // R10: pause in a fetch cycle with a pending request
    @(negedge clk);
    req_valid_i = 1'b1; req_write_i = 1'b1; req_size_i = 2'd0;
    req_addr_i = 32'h0000_6002; req_wdata_i = 32'h0000_0077;
    pause_i = 1'b1;
    #1;
    chk("R10 stall under pause", {31'd0, st_b}, 32'd1);
    chk("R10 early addr holds", {2'b00, an_b}, 32'h0000_3000);
    @(posedge clk); #2;
    chk("R10 addr held", {2'b00, a_b}, 32'h0000_3000);
    chk("R10 be held", {28'd0, b_b}, 32'd0);
    pause_i = 1'b0;
    @(posedge clk); #2;
    chk("R3 data after pause", {2'b00, a_b}, 32'h0000_1800);
    chk("R4 be after pause", {28'd0, b_b}, 32'h0000_0002);
    // R10: pause stretches the data cycle
    req_valid_i  = 1'b0;
    fetch_addr_i = 30'h0000_3100;
    pause_i      = 1'b1;
    @(posedge clk); #2;
    chk("R10 data addr held", {2'b00, a_b}, 32'h0000_1800);
    chk("R10 wdata held", w_b, 32'h7777_7777);
    pause_i = 1'b0;
    @(posedge clk); #2;
    chk("R3 fetch after paused data", {2'b00, a_b}, 32'h0000_3100);
    chk("R3 be after paused data", {28'd0, b_b}, 32'd0);

    report();
  end
endmodule